// File: doc/BRIEF.md
# Card-Side Query Matcher and Reply Serializer

This block sits behind a pulse-interval bit decoder on the card side of a contactless link. Each time the decoder closes a frame, it hands over a bit count and a data word. The block discards frames that carry too few bits to mean anything. It also discards one reserved frame length without consulting its table. Any other frame is compared in parallel against a fixed table of queries, which is set by parameters.

When a query matches, the block answers with the paired reply word. The reply goes out on a single serial line, least-significant bit first, with each bit held for a fixed number of timer ticks. The reply does not start as soon as the match is found. It waits until the decoder's running interval count, measured from the last reader edge, reaches a fixed start offset. If that offset has already passed, the first bit goes out on the next tick.

A match flag reports the result of the most recent table check. A busy flag covers the time from the match to the end of the last bit. Frames that arrive while busy is high are dropped.

Top module: `frame_responder`

## Requirements
- R1: A frame whose bit count is 4 or less is dropped: no reply is sent, busy stays low and match_o keeps its value.
- R2: A frame of exactly 6 bits is dropped without a table check: no reply is sent, busy stays low and match_o keeps its value, even where a check would have missed.
- R3: A frame is a hit only when both its bit count and its 16-bit data equal those of a table entry. A check that finds no entry clears match_o one cycle after the frame and starts no reply.
- R4: When more than one entry matches, the entry with the lowest index (entry 0 is bits [15:0] / [3:0] of the packed table parameters) supplies the reply.
- R5: The default table answers a 7-bit query of value 0x55 with a 6-bit reply of value 0x3B.
- R6: sdata_o is low whenever busy_o is low, which includes before the first reply bit and after the last one.
- R7: The first reply bit appears on sdata_o in the cycle after the first tick (tick_i high) whose tick_count_i is 490 or more.
- R8: Reply bits go out least-significant bit first, and each bit is held for exactly 150 ticks. Bit k is therefore on the line after the tick at start+150k, until the tick at start+150(k+1).
- R9: If tick_count_i is already past 490 when the match happens, the first bit appears after the very next tick.
- R10: match_o rises one cycle after a frame that hits.
- R11: busy_o rises one cycle after a matching frame and falls after the tick that ends the last bit period. A frame presented while busy_o is high is dropped: match_o does not change and the reply in flight is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One-cycle strobe: a completed frame is on the frame inputs |
| frame_bits_i | input | 4 | Number of bits in the frame |
| frame_data_i | input | 16 | Frame bits, first received bit in bit 0, upper bits zero |
| tick_i | input | 1 | Single-cycle timer tick enable |
| tick_count_i | input | 12 | Ticks counted since the last reader rising edge |
| sdata_o | output | 1 | Serial reply data |
| busy_o | output | 1 | A reply is pending or being sent |
| match_o | output | 1 | Result of the most recent table check |

## Verification
Some rules are checked by the assertions on every cycle:
- the line stays low while idle;
- a reply starts only on a tick at or past the offset;
- a bit never changes except at the end of its bit period;
- short frames, reserved-length frames and frames that arrive while busy leave both flags untouched.

Other behaviour only the directed scenarios can show:
- the exact reply bit pattern and its LSB-first order;
- the tick at which each bit starts and ends;
- the late-start case;
- priority between duplicate table entries;
- that a reply in flight survives a frame dropped during busy.

// File: rtl/frame_responder_pkg.sv
package frame_responder_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/frame_gate.sv
module frame_gate #(
  parameter int LEN_W     = 4,
  parameter int EMPTY_MAX = 4,
  parameter int SKIP_LEN  = 6
) (
  input  logic             accept_i,
  input  logic [LEN_W-1:0] bits_i,
  output logic             check_o
);
  logic too_short, reserved;

  assign too_short = bits_i <= LEN_W'(EMPTY_MAX);
  assign reserved  = bits_i == LEN_W'(SKIP_LEN);
  assign check_o   = accept_i && !too_short && !reserved;
endmodule

// File: rtl/query_table.sv
module query_table #(
  parameter int LEN_W   = 4,
  parameter int DATA_W  = 16,
  parameter int ENTRIES = 1,
  parameter logic [ENTRIES*LEN_W-1:0]  Q_LEN  = '0,
  parameter logic [ENTRIES*DATA_W-1:0] Q_DATA = '0,
  parameter logic [ENTRIES*LEN_W-1:0]  R_LEN  = '0,
  parameter logic [ENTRIES*DATA_W-1:0] R_DATA = '0
) (
  input  logic [LEN_W-1:0]  bits_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output logic [LEN_W-1:0]  resp_len_o,
  output logic [DATA_W-1:0] resp_data_o
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = (bits_i == Q_LEN[i*LEN_W +: LEN_W]) &&
                        (data_i == Q_DATA[i*DATA_W +: DATA_W]);
  end

  // scan downward so the lowest index overrides
  always_comb begin
    hit_o       = 1'b0;
    resp_len_o  = '0;
    resp_data_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_o       = 1'b1;
        resp_len_o  = R_LEN[i*LEN_W +: LEN_W];
        resp_data_o = R_DATA[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/resp_serializer.sv
module resp_serializer
  import frame_responder_pkg::*;
#(
  parameter int LEN_W      = 4,
  parameter int DATA_W     = 16,
  parameter int COUNT_W    = 12,
  parameter int START_TICK = 490,
  parameter int BIT_TICKS  = 150
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               tick_i,
  input  logic [COUNT_W-1:0] tick_count_i,
  output logic               sdata_o,
  output logic               busy_o
);
  localparam int TIMER_W = $clog2(BIT_TICKS);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(BIT_TICKS - 1);

  tx_state_e          state_q;
  logic [DATA_W-1:0]  shreg_q;
  logic [LEN_W-1:0]   left_q;
  logic [TIMER_W-1:0] timer_q;
  logic               sdata_q;
  logic               sending;

  assign sending = state_q == TX_SEND;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      timer_q <= '0;
      sdata_q <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (load_i) begin
            state_q <= TX_WAIT;
            shreg_q <= data_i;
            left_q  <= len_i;
          end
        end
        TX_WAIT: begin
          if (tick_i && tick_count_i >= COUNT_W'(START_TICK)) begin
            state_q <= TX_SEND;
            sdata_q <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            timer_q <= '0;
          end
        end
        TX_SEND: begin
          if (tick_i) begin
            if (timer_q == TIMER_LAST) begin
              timer_q <= '0;
              if (left_q == LEN_W'(1)) begin
                state_q <= TX_IDLE;
                sdata_q <= 1'b0;
                left_q  <= '0;
              end else begin
                sdata_q <= shreg_q[0];
                shreg_q <= shreg_q >> 1;
                left_q  <= left_q - LEN_W'(1);
              end
            end else begin
              timer_q <= timer_q + TIMER_W'(1);
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign sdata_o = sdata_q;
  assign busy_o  = state_q != TX_IDLE;

  AST_IDLE_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sdata_o); // R6
  AST_START_AT_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sending) |-> ($past(tick_i) && ($past(tick_count_i) >= COUNT_W'(START_TICK)))); // R7
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sending && !(tick_i && timer_q == TIMER_LAST)) |=> $stable(sdata_o)); // R8
endmodule

// File: rtl/frame_responder.sv
module frame_responder #(
  parameter int LEN_W      = 4,
  parameter int DATA_W     = 16,
  parameter int COUNT_W    = 12,
  parameter int EMPTY_MAX  = 4,
  parameter int SKIP_LEN   = 6,
  parameter int START_TICK = 490,
  parameter int BIT_TICKS  = 150,
  parameter int ENTRIES    = 1,
  parameter logic [ENTRIES*LEN_W-1:0]  QUERY_LEN  = 4'd7,
  parameter logic [ENTRIES*DATA_W-1:0] QUERY_DATA = 16'h0055,
  parameter logic [ENTRIES*LEN_W-1:0]  RESP_LEN   = 4'd6,
  parameter logic [ENTRIES*DATA_W-1:0] RESP_DATA  = 16'h003B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_valid_i,
  input  logic [LEN_W-1:0]   frame_bits_i,
  input  logic [DATA_W-1:0]  frame_data_i,
  input  logic               tick_i,
  input  logic [COUNT_W-1:0] tick_count_i,
  output logic               sdata_o,
  output logic               busy_o,
  output logic               match_o
);
  logic              accept, check, hit, load, match_q;
  logic [LEN_W-1:0]  resp_len;
  logic [DATA_W-1:0] resp_data;

  assign accept = frame_valid_i && !busy_o;

  frame_gate #(
    .LEN_W(LEN_W), .EMPTY_MAX(EMPTY_MAX), .SKIP_LEN(SKIP_LEN)
  ) u_gate (
    .accept_i(accept), .bits_i(frame_bits_i), .check_o(check)
  );

  query_table #(
    .LEN_W(LEN_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES),
    .Q_LEN(QUERY_LEN), .Q_DATA(QUERY_DATA), .R_LEN(RESP_LEN), .R_DATA(RESP_DATA)
  ) u_table (
    .bits_i(frame_bits_i), .data_i(frame_data_i), .hit_o(hit),
    .resp_len_o(resp_len), .resp_data_o(resp_data)
  );

  assign load = check && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    match_q <= 1'b0;
    else if (check) match_q <= hit;
  end
  assign match_o = match_q;

  resp_serializer #(
    .LEN_W(LEN_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W),
    .START_TICK(START_TICK), .BIT_TICKS(BIT_TICKS)
  ) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .len_i(resp_len),
    .data_i(resp_data), .tick_i(tick_i), .tick_count_i(tick_count_i),
    .sdata_o(sdata_o), .busy_o(busy_o)
  );

  AST_EMPTY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !busy_o && frame_bits_i <= LEN_W'(EMPTY_MAX)) |=> ($stable(match_o) && !busy_o)); // R1
  AST_SKIP_LEN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !busy_o && frame_bits_i == LEN_W'(SKIP_LEN)) |=> ($stable(match_o) && !busy_o)); // R2
  AST_MATCH_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(match_o)); // R11
endmodule

// File: tb/frame_responder_test.sv
module frame_responder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_valid_i = 1'b0;
  logic [3:0]  frame_bits_i = '0;
  logic [15:0] frame_data_i = '0;
  logic        tick_i = 1'b0;
  logic [11:0] tick_count_i = '0;
  logic        sdata_o, busy_o, match_o;
  logic        sdata2, busy2, match2;

  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  frame_responder uut (
    .clk_i, .rst_ni, .frame_valid_i, .frame_bits_i, .frame_data_i,
    .tick_i, .tick_count_i, .sdata_o, .busy_o, .match_o
  );

  // two entries with the same query: entry 0 must win
  frame_responder #(
    .ENTRIES(2),
    .QUERY_LEN({4'd5, 4'd5}), .QUERY_DATA({16'h000A, 16'h000A}),
    .RESP_LEN({4'd4, 4'd4}),  .RESP_DATA({16'h0006, 16'h0009})
  ) uut2 (
    .clk_i, .rst_ni, .frame_valid_i, .frame_bits_i, .frame_data_i,
    .tick_i, .tick_count_i, .sdata_o(sdata2), .busy_o(busy2), .match_o(match2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [3:0] bits, input logic [15:0] data);
    @(negedge clk_i);
    frame_valid_i = 1'b1;
    frame_bits_i  = bits;
    frame_data_i  = data;
    @(posedge clk_i);
    @(negedge clk_i);
    frame_valid_i = 1'b0;
  endtask

  // one tick followed by an idle cycle; returns sampled after the tick edge
  task automatic tick_at(input int c);
    @(negedge clk_i);
    tick_i = 1'b1;
    tick_count_i = 12'(c);
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 1'b0;
    @(posedge clk_i);
  endtask

  task automatic run_tx(input bit sel, input int first_c, input int s,
                        input int len, input logic [15:0] data);
    for (int c = first_c; c <= s + 150 * len; c++) begin
      logic sd, bz;
      tick_at(c);
      #1;
      sd = sel ? sdata2 : sdata_o;
      bz = sel ? busy2 : busy_o;
      if (c == s - 1) begin
        check("R6 line low before first bit", 32'(sd), 0);
        check("R11 busy while waiting", 32'(bz), 1);
      end else if (c == s + 150 * len) begin
        check("R6 line low after last bit", 32'(sd), 0);
        check("R11 busy ends after last bit", 32'(bz), 0);
      end else if (c >= s) begin
        int k = (c - s) / 150;
        int r = (c - s) % 150;
        if (r == 0 || r == 149)
          check("R8 bit value LSB first", 32'(sd), 32'(data[k]));
        if (c == s) check("R7 R9 first bit starts", 32'(sd), 32'(data[0]));
      end
    end
  endtask

  task automatic t_reset;
    check("R6 reset sdata", 32'(sdata_o), 0);
    check("R11 reset busy", 32'(busy_o), 0);
    check("R10 reset match", 32'(match_o), 0);
  endtask

  task automatic t_default_reply;
    send_frame(4'd7, 16'h0055);
    check("R10 match set", 32'(match_o), 1);
    check("R5 busy after hit", 32'(busy_o), 1);
    run_tx(1'b0, 1, 490, 6, 16'h003B);
  endtask

  task automatic t_ignored;
    send_frame(4'd4, 16'h0055);
    check("R1 short keeps match", 32'(match_o), 1);
    check("R1 short no busy", 32'(busy_o), 0);
    send_frame(4'd2, 16'h0001);
    check("R1 tiny keeps match", 32'(match_o), 1);
    send_frame(4'd6, 16'h003B);
    check("R2 six bits keeps match", 32'(match_o), 1);
    check("R2 six bits no busy", 32'(busy_o), 0);
    repeat (4) tick_at(600);
    check("R2 line stays low", 32'(sdata_o), 0);
  endtask

  task automatic t_mismatch;
    send_frame(4'd7, 16'h0054);
    check("R3 data miss clears match", 32'(match_o), 0);
    check("R3 data miss no busy", 32'(busy_o), 0);
    send_frame(4'd7, 16'h0055);
    check("R10 rematch", 32'(match_o), 1);
    run_tx(1'b0, 1, 490, 6, 16'h003B);
    send_frame(4'd8, 16'h0055);
    check("R3 length miss clears match", 32'(match_o), 0);
    check("R3 length miss no busy", 32'(busy_o), 0);
  endtask

  task automatic t_late_start;
    send_frame(4'd7, 16'h0055);
    check("R9 busy on late hit", 32'(busy_o), 1);
    run_tx(1'b0, 601, 601, 6, 16'h003B);
  endtask

  task automatic t_busy_drop;
    send_frame(4'd7, 16'h0055);
    for (int c = 1; c <= 10; c++) tick_at(c);
    send_frame(4'd7, 16'h0054);
    check("R11 miss during busy dropped", 32'(match_o), 1);
    check("R11 still busy", 32'(busy_o), 1);
    for (int c = 11; c <= 500; c++) tick_at(c);
    send_frame(4'd8, 16'h0000);
    check("R11 drop mid reply keeps match", 32'(match_o), 1);
    check("R11 drop mid reply keeps bit", 32'(sdata_o), 1);
    run_tx(1'b0, 501, 490, 6, 16'h003B);
  endtask

  task automatic t_priority;
    send_frame(4'd5, 16'h000A);
    check("R4 second dut match", 32'(match2), 1);
    check("R3 main dut miss", 32'(match_o), 0);
    run_tx(1'b1, 1, 490, 4, 16'h0009);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_default_reply();
    t_ignored();
    t_mismatch();
    t_late_start();
    t_busy_drop();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule